// File: doc/BRIEF.md
# Debug Trigger Sequencer

This block steps a debug session through a short chain of states as qualifying events arrive. Each comparator channel signals a match. A per-channel mode bit decides how that match counts. In forced mode the match acts in the same clock. In tagged mode the match only marks an instruction, and the sequencer waits for the CPU to report, through a tag-hit pulse, that the instruction has reached execution. A software trigger write acts without any comparator event. What it does depends on the tracing alignment: with begin alignment it jumps to the Final state; with end alignment it closes the session and requests a breakpoint.

The session is armed by a pulse, which enters State1 and clears the status flags. In each of State1, State2 and State3 there is a control field for each channel that names the state to take next when that channel wins. Sticky flags record which event caused each transition. A single-cycle breakpoint request is raised when Final is reached with breakpoints enabled, and always when an end-aligned software trigger fires.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, state_o is Disarmed (code 0), armed_o is 0, flags_o is all zero and brk_req_o is 0. State codes are Disarmed 0, State1 1, State2 2, State3 3 and Final 4.
- R2: An arm_i pulse sets state_o to State1 and armed_o to 1 and clears flags_o on the following clock. This applies from any state, and arm_i takes priority over every other event in the same cycle.
- R3: While disarmed, match, tag-hit and software trigger inputs are ignored: state_o stays 0, flags_o keeps its value and brk_req_o stays 0.
- R4: Channel c is in forced mode when tag_mode_i[c] is 0. In State s (1 to 3), a match_i[c] pulse moves the sequencer to the state named by the 2-bit field next_cfg_i[((s-1)*NCOMP+c)*2 +: 2]. Code k in that field selects state code k+1, so code 3 selects Final. The same pulse sets flags_o[c].
- R5: Channel c is in tagged mode when tag_mode_i[c] is 1. Its match_i pulse alone has no effect. Its taghit_i[c] pulse moves the sequencer by the same field as in R4 and sets flags_o[NCOMP+c]. A taghit_i pulse on a forced-mode channel is ignored.
- R6: When several events qualify in one cycle, a forced match beats a tag hit, and among events of the same kind the lowest channel index wins. Only the winning event's flag is set.
- R7: Flags are sticky. They accumulate across later transitions and survive disarming, and are cleared only by arm_i.
- R8: With end_align_i 0, a software trigger in State1 to State3 moves to Final and sets flags_o[2*NCOMP]. It overrides any comparator event in the same cycle.
- R9: With end_align_i 1, a software trigger while armed moves to Disarmed, clears armed_o, sets flags_o[2*NCOMP], and raises brk_req_o for one clock regardless of brk_en_i.
- R10: A transition into Final raises brk_req_o for exactly one clock, in the cycle after the event, when brk_en_i is 1. When brk_en_i is 0 it raises nothing.
- R11: In Final, comparator matches and tag hits are ignored, and the state stays Final.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm pulse: enter State1 and clear flags |
| match_i | input | NCOMP | Per-channel comparator match pulse |
| tag_mode_i | input | NCOMP | Per-channel mode: 0 forced, 1 tagged |
| taghit_i | input | NCOMP | Per-channel CPU tag-hit pulse |
| sw_trig_i | input | 1 | Software trigger write pulse |
| end_align_i | input | 1 | Tracing alignment: 0 begin, 1 end |
| brk_en_i | input | 1 | Breakpoint enable on reaching Final |
| next_cfg_i | input | 6*NCOMP | Next-state fields, 2 bits per state and channel |
| state_o | output | 3 | Current state code |
| armed_o | output | 1 | Session armed |
| flags_o | output | 2*NCOMP+1 | Sticky cause flags: forced, tagged, software |
| brk_req_o | output | 1 | Breakpoint request pulse |

## Verification
The sequencer is driven through a forced-only chain from State1 to Final, so that each hop has to follow its own configuration field. A separate run uses a tagged channel, where a bare match, a tag hit on a forced channel and a real tag hit are applied one after another; this separates the two event kinds. Cycles that combine a forced match with a tag hit, or two forced matches at once, show the priority order. Software triggers are applied under both alignments and both breakpoint-enable settings, with a competing comparator match in the same cycle, to separate the jump to Final from the disarm path and to show which of them requests a breakpoint.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int unsigned SEQ_STATES = 3;   // intermediate states with control fields
  localparam int unsigned CODE_W     = 2;   // next-state field width

  typedef enum logic [2:0] {
    ST_DISARMED = 3'd0,
    ST_S1       = 3'd1,
    ST_S2       = 3'd2,
    ST_S3       = 3'd3,
    ST_FINAL    = 3'd4
  } seq_state_e;

  function automatic seq_state_e code_to_state(input logic [CODE_W-1:0] code);
    return seq_state_e'({1'b0, code} + 3'd1);
  endfunction
endpackage

// File: rtl/dbg_evt_pick.sv
module dbg_evt_pick #(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     oh_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    oh_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        oh_o  = N'(1) << i;
      end
    end
  end

  assign hit_o = |req_i;
endmodule

// File: rtl/dbg_next_lut.sv
module dbg_next_lut
  import dbg_seq_pkg::*;
#(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
  parameter int unsigned CFG_W = SEQ_STATES * N * CODE_W
) (
  input  logic [CFG_W-1:0] cfg_i,
  input  seq_state_e       cur_i,
  input  logic [IDX_W-1:0] idx_i,
  output seq_state_e       nxt_o
);
  logic [CODE_W-1:0] code;
  int unsigned       row;
  int unsigned       base;

  always_comb begin
    unique case (cur_i)
      ST_S2:   row = 1;
      ST_S3:   row = 2;
      default: row = 0;
    endcase
    base = (row * N + int'(idx_i)) * CODE_W;
    if (base > CFG_W - CODE_W) base = 0;
    code = cfg_i[base +: CODE_W];
  end

  assign nxt_o = code_to_state(code);
endmodule

// File: rtl/dbg_flag_reg.sv
module dbg_flag_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= q_o | set_i;
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_seq_pkg::*;
#(
  parameter int unsigned NCOMP = 3
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 arm_i,
  input  logic [NCOMP-1:0]                     match_i,
  input  logic [NCOMP-1:0]                     tag_mode_i,
  input  logic [NCOMP-1:0]                     taghit_i,
  input  logic                                 sw_trig_i,
  input  logic                                 end_align_i,
  input  logic                                 brk_en_i,
  input  logic [SEQ_STATES*NCOMP*CODE_W-1:0]   next_cfg_i,
  output logic [2:0]                           state_o,
  output logic                                 armed_o,
  output logic [2*NCOMP:0]                     flags_o,
  output logic                                 brk_req_o
);
  localparam int unsigned IDX_W  = (NCOMP > 1) ? $clog2(NCOMP) : 1;
  localparam int unsigned CFG_W  = SEQ_STATES * NCOMP * CODE_W;
  localparam int unsigned FLAG_W = 2 * NCOMP + 1;
  localparam int unsigned SW_BIT = 2 * NCOMP;

  seq_state_e        state_q, state_d, nxt_state;
  logic              armed_q, armed_d;
  logic              brk_q, brk_d;
  logic              flag_clr;
  logic [FLAG_W-1:0] flag_set;

  logic [NCOMP-1:0]  forced_req, tag_req;
  logic              f_hit, t_hit;
  logic [IDX_W-1:0]  f_idx, t_idx, sel_idx;
  logic [NCOMP-1:0]  f_oh, t_oh;
  logic              in_seq;

  assign forced_req = match_i & ~tag_mode_i;
  assign tag_req    = taghit_i & tag_mode_i;

  dbg_evt_pick #(.N(NCOMP), .IDX_W(IDX_W)) u_pick_forced (
    .req_i(forced_req), .hit_o(f_hit), .idx_o(f_idx), .oh_o(f_oh)
  );

  dbg_evt_pick #(.N(NCOMP), .IDX_W(IDX_W)) u_pick_tag (
    .req_i(tag_req), .hit_o(t_hit), .idx_o(t_idx), .oh_o(t_oh)
  );

  assign sel_idx = f_hit ? f_idx : t_idx;

  dbg_next_lut #(.N(NCOMP), .IDX_W(IDX_W), .CFG_W(CFG_W)) u_lut (
    .cfg_i(next_cfg_i), .cur_i(state_q), .idx_i(sel_idx), .nxt_o(nxt_state)
  );

  assign in_seq = armed_q && (state_q inside {ST_S1, ST_S2, ST_S3});

  always_comb begin
    state_d  = state_q;
    armed_d  = armed_q;
    brk_d    = 1'b0;
    flag_clr = 1'b0;
    flag_set = '0;
    if (arm_i) begin
      state_d  = ST_S1;
      armed_d  = 1'b1;
      flag_clr = 1'b1;
    end else if (armed_q) begin
      if (sw_trig_i) begin
        if (end_align_i) begin
          state_d          = ST_DISARMED;
          armed_d          = 1'b0;
          brk_d            = 1'b1;
          flag_set[SW_BIT] = 1'b1;
        end else if (state_q != ST_FINAL) begin
          state_d          = ST_FINAL;
          brk_d            = brk_en_i;
          flag_set[SW_BIT] = 1'b1;
        end
      end else if (in_seq && f_hit) begin
        state_d               = nxt_state;
        brk_d                 = brk_en_i && (nxt_state == ST_FINAL);
        flag_set[NCOMP-1:0]   = f_oh;
      end else if (in_seq && t_hit) begin
        state_d                   = nxt_state;
        brk_d                     = brk_en_i && (nxt_state == ST_FINAL);
        flag_set[2*NCOMP-1:NCOMP] = t_oh;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DISARMED;
      armed_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      brk_q   <= brk_d;
    end
  end

  dbg_flag_reg #(.W(FLAG_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(flag_clr), .set_i(flag_set), .q_o(flags_o)
  );

  assign state_o   = state_q;
  assign armed_o   = armed_q;
  assign brk_req_o = brk_q;
endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk
  import dbg_seq_pkg::*;
#(
  parameter int unsigned NCOMP = 3
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               arm_i,
  input logic [NCOMP-1:0]                   match_i,
  input logic [NCOMP-1:0]                   tag_mode_i,
  input logic [NCOMP-1:0]                   taghit_i,
  input logic                               sw_trig_i,
  input logic                               end_align_i,
  input logic                               brk_en_i,
  input logic [SEQ_STATES*NCOMP*CODE_W-1:0] next_cfg_i,
  input logic [2:0]                         state_o,
  input logic                               armed_o,
  input logic [2*NCOMP:0]                   flags_o,
  input logic                               brk_req_o
);
  assert_armed_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o == (state_o != 3'd0));

  assert_arm_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (state_o == 3'd1) && armed_o && (flags_o == '0));

  assert_disarmed_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !arm_i) |=> !armed_o && $stable(flags_o) && !brk_req_o);

  assert_single_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> $countones(flags_o & ~$past(flags_o)) <= 1);

  assert_flags_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_end_trig_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !arm_i && sw_trig_i && end_align_i) |=> !armed_o && brk_req_o);

  assert_brk_context_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> (state_o == 3'd4) || !armed_o);

  assert_final_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && !arm_i && !sw_trig_i) |=> state_o == 3'd4);
endmodule

bind dbg_trig_seq dbg_trig_seq_chk #(.NCOMP(NCOMP)) u_chk (.*);

// File: tb/tb_dbg_trig_seq.sv
module tb_dbg_trig_seq;
  localparam int N     = 3;
  localparam int CFG_W = 3 * N * 2;
  localparam int FW    = 2 * N + 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             arm_i = 1'b0;
  logic [N-1:0]     match_i = '0;
  logic [N-1:0]     tag_mode_i = '0;
  logic [N-1:0]     taghit_i = '0;
  logic             sw_trig_i = 1'b0;
  logic             end_align_i = 1'b0;
  logic             brk_en_i = 1'b0;
  logic [CFG_W-1:0] next_cfg_i = '0;
  logic [2:0]       state_o;
  logic             armed_o;
  logic [FW-1:0]    flags_o;
  logic             brk_req_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  dbg_trig_seq #(.NCOMP(N)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setcfg(input int s, input int c, input logic [1:0] code);
    next_cfg_i[((s - 1) * N + c) * 2 +: 2] = code;
  endtask

  task automatic cyc(input logic a, input logic [N-1:0] m, input logic [N-1:0] th, input logic sw);
    arm_i = a; match_i = m; taghit_i = th; sw_trig_i = sw;
    @(posedge clk_i); #1;
    arm_i = 1'b0; match_i = '0; taghit_i = '0; sw_trig_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 state", state_o, 0);
    check("R1 armed", armed_o, 0);
    check("R1 flags", flags_o, 0);
    check("R1 brk", brk_req_o, 0);
  endtask

  task automatic t_disarmed;
    cyc(0, 3'b111, 3'b111, 1'b1);
    check("R3 state", state_o, 0);
    check("R3 flags", flags_o, 0);
    check("R3 brk", brk_req_o, 0);
  endtask

  task automatic t_forced_chain;
    tag_mode_i = '0; brk_en_i = 1'b1; end_align_i = 1'b0;
    setcfg(1, 1, 2'd1); setcfg(2, 0, 2'd2); setcfg(3, 2, 2'd3);
    cyc(1, '0, '0, 0);
    check("R2 state", state_o, 1);
    check("R2 armed", armed_o, 1);
    cyc(0, 3'b010, '0, 0);
    check("R4 s1->s2", state_o, 2);
    check("R4 flag", flags_o, 7'h02);
    cyc(0, 3'b001, '0, 0);
    check("R4 s2->s3", state_o, 3);
    check("R7 sticky", flags_o, 7'h03);
    check("R10 no brk", brk_req_o, 0);
    cyc(0, 3'b100, '0, 0);
    check("R4 s3->final", state_o, 4);
    check("R7 sticky", flags_o, 7'h07);
    check("R10 brk", brk_req_o, 1);
    cyc(0, 3'b001, 3'b111, 0);
    check("R10 pulse end", brk_req_o, 0);
    check("R11 hold", state_o, 4);
    check("R11 flags", flags_o, 7'h07);
  endtask

  task automatic t_tagged;
    next_cfg_i = '0;
    setcfg(1, 0, 2'd2);
    tag_mode_i = 3'b001;
    cyc(1, '0, '0, 0);
    check("R2 rearm flags", flags_o, 0);
    check("R2 rearm state", state_o, 1);
    cyc(0, 3'b001, '0, 0);
    check("R5 match alone", state_o, 1);
    cyc(0, '0, 3'b010, 0);
    check("R5 forced taghit", state_o, 1);
    check("R5 no flag", flags_o, 0);
    cyc(0, '0, 3'b001, 0);
    check("R5 taghit", state_o, 3);
    check("R5 flag", flags_o, 7'h08);
  endtask

  task automatic t_priority;
    next_cfg_i = '0;
    setcfg(1, 1, 2'd1); setcfg(1, 2, 2'd2);
    tag_mode_i = 3'b100;
    cyc(1, '0, '0, 0);
    cyc(0, 3'b010, 3'b100, 0);
    check("R6 forced wins", state_o, 2);
    check("R6 one flag", flags_o, 7'h02);
    tag_mode_i = '0;
    cyc(1, 3'b110, '0, 0);
    check("R2 arm priority", state_o, 1);
    check("R2 arm clears", flags_o, 0);
    cyc(0, 3'b110, '0, 0);
    check("R6 low index", state_o, 2);
    check("R6 low flag", flags_o, 7'h02);
  endtask

  task automatic t_begin_sw;
    next_cfg_i = '0; setcfg(1, 1, 2'd1);
    tag_mode_i = '0; end_align_i = 1'b0; brk_en_i = 1'b0;
    cyc(1, '0, '0, 0);
    cyc(0, 3'b010, '0, 1);
    check("R8 final", state_o, 4);
    check("R8 flag", flags_o, 7'h40);
    check("R10 disabled", brk_req_o, 0);
    brk_en_i = 1'b1;
    cyc(1, '0, '0, 0);
    cyc(0, '0, '0, 1);
    check("R10 sw brk", brk_req_o, 1);
  endtask

  task automatic t_end_sw;
    end_align_i = 1'b1; brk_en_i = 1'b0;
    cyc(1, '0, '0, 0);
    cyc(0, 3'b001, '0, 1);
    check("R9 state", state_o, 0);
    check("R9 armed", armed_o, 0);
    check("R9 brk", brk_req_o, 1);
    check("R9 flag", flags_o, 7'h40);
    cyc(0, 3'b001, '0, 1);
    check("R9 pulse end", brk_req_o, 0);
    check("R7 kept disarmed", flags_o, 7'h40);
    check("R3 still disarmed", state_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_disarmed();
    t_forced_chain();
    t_tagged();
    t_priority();
    t_begin_sw();
    t_end_sw();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule